// File: doc/BRIEF.md
# Exception entry controller

This block sits beside the fetch stage of a 32-bit processor and performs the single-cycle bookkeeping of taking an exception. When a request arrives with a 3-bit type index, the block decides whether the type belongs to the normal class or the debug class. It saves the current program counter into that class's link register and records the global interrupt enable into that class's saved-enable bit. It then clears the global enable and produces the handler address for fetch. A one-cycle `taken` pulse tells the pipeline to flush and redirect.

The handler address is a base address with its low 8 bits forced to zero, plus 32 bytes for each step of the type index. A normal exception uses the normal base. When the remap control bit is set, a normal exception uses the debug base instead. A debug exception always uses the debug base. A type index outside the handled set raises a one-cycle error pulse and changes no state. Software can write the global enable through a plain write strobe.

The request is a plain control pulse with no back-pressure. The block accepts a request in every cycle and completes it in that same cycle, so it has no ready signal. Outputs are registered and appear one cycle after the request edge.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The type index is encoded as 0 = reset, 1 = breakpoint, 2 = instruction bus error, 3 = watchpoint, 4 = data bus error, 5 = divide by zero, 6 = interrupt, 7 = system call. Index 0 is not handled: a request with it pulses `bad_type` for one cycle, gives no `taken`, and leaves the enable bits and link registers unchanged.
- R2: A request with index 2, 4, 5, 6 or 7 (normal class) stores `cur_pc` into `link_exc` and leaves `link_dbg` unchanged.
- R3: A request with index 1 or 3 (debug class) stores `cur_pc` into `link_dbg` and leaves `link_exc` unchanged.
- R4: A normal entry sets `gie_sav_exc` when `gie` was 1 beforehand, and a debug entry does the same for `gie_sav_dbg`. Exception entry never clears either saved bit.
- R5: Every accepted exception clears `gie`. This takes priority over a global-enable write in the same cycle.
- R6: `target_pc` equals the selected base with bits 7:0 zeroed, plus the type index times 32.
- R7: A normal exception selects `norm_base` when `remap_en` is 0 and `dbg_base` when `remap_en` is 1.
- R8: A debug exception selects `dbg_base` whatever the value of `remap_en`.
- R9: `taken` is high for exactly the one cycle after the clock edge that accepted a request. `target_pc` and the link registers hold their new values in that same cycle.
- R10: Synchronous reset clears `gie`, both saved-enable bits, both link registers, `taken` and `bad_type`.
- R11: When no exception is accepted, `ie_wr` loads `ie_wr_val` into `gie` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request strobe |
| exc_idx | input | 3 | Exception type index |
| cur_pc | input | 32 | Program counter of the excepting instruction |
| norm_base | input | 32 | Normal exception vector base |
| dbg_base | input | 32 | Debug exception vector base |
| remap_en | input | 1 | Route normal exceptions to the debug base |
| ie_wr | input | 1 | Global enable write strobe |
| ie_wr_val | input | 1 | Value for the global enable write |
| taken | output | 1 | One-cycle exception-taken pulse |
| target_pc | output | 32 | Handler address |
| bad_type | output | 1 | One-cycle unhandled-type pulse |
| gie | output | 1 | Global interrupt enable |
| gie_sav_exc | output | 1 | Enable saved by a normal exception |
| gie_sav_dbg | output | 1 | Enable saved by a debug exception |
| link_exc | output | 32 | Return address of a normal exception |
| link_dbg | output | 32 | Return address of a debug exception |

## Verification
Every type index is swept against both values of the prior global enable and both values of the remap bit. This separates the class decode, the link register chosen, the saved bit set and the base selected. The two bases differ and are deliberately unaligned, so a missing alignment mask or a swapped base shows up at once. Further directed sequences repeat an entry with the enable low, to tell a sticky saved bit from a copied one, and collide an enable write with an entry. They also send an unhandled index after state has been loaded, so that "unchanged" is checked against nonzero values.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    EXC_RESET   = 3'd0,
    EXC_BREAK   = 3'd1,
    EXC_IBUS    = 3'd2,
    EXC_WATCH   = 3'd3,
    EXC_DBUS    = 3'd4,
    EXC_DIVZ    = 3'd5,
    EXC_IRQ     = 3'd6,
    EXC_SYSCALL = 3'd7
  } exc_kind_e;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_NORMAL = 2'd1,
    CLS_DEBUG  = 2'd2
  } exc_class_e;
endpackage

// File: rtl/exc_class_decode.sv
module exc_class_decode
  import exc_entry_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output exc_class_e       cls
);
  always_comb begin
    unique case (exc_kind_e'(idx))
      EXC_BREAK, EXC_WATCH:                            cls = CLS_DEBUG;
      EXC_IBUS, EXC_DBUS, EXC_DIVZ, EXC_IRQ, EXC_SYSCALL: cls = CLS_NORMAL;
      default:                                         cls = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned SLOT_SHIFT = 5
) (
  input  exc_class_e       cls,
  input  logic             remap_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  norm_base,
  input  logic [XLEN-1:0]  dbg_base,
  output logic [XLEN-1:0]  vec_pc
);
  localparam int unsigned ALIGN_W = IDX_W + SLOT_SHIFT;

  logic [XLEN-1:0] base_sel;

  always_comb begin
    if (cls == CLS_DEBUG || remap_en) base_sel = dbg_base;
    else                              base_sel = norm_base;
  end

  // The slot offset fits below the alignment boundary, so no adder is needed.
  assign vec_pc = {base_sel[XLEN-1:ALIGN_W], idx, {SLOT_SHIFT{1'b0}}};
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire_norm,
  input  logic            fire_dbg,
  input  logic            fire_bad,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] vec_pc,
  input  logic            ie_wr,
  input  logic            ie_wr_val,
  output logic            taken,
  output logic            bad_type,
  output logic [XLEN-1:0] target_pc,
  output logic            gie,
  output logic            gie_sav_exc,
  output logic            gie_sav_dbg,
  output logic [XLEN-1:0] link_exc,
  output logic [XLEN-1:0] link_dbg
);
  logic fire_any;
  assign fire_any = fire_norm | fire_dbg;

  always_ff @(posedge clk) begin
    if (rst) begin
      taken       <= 1'b0;
      bad_type    <= 1'b0;
      target_pc   <= '0;
      gie         <= 1'b0;
      gie_sav_exc <= 1'b0;
      gie_sav_dbg <= 1'b0;
      link_exc    <= '0;
      link_dbg    <= '0;
    end else begin
      taken    <= fire_any;
      bad_type <= fire_bad;
      if (fire_any) begin
        target_pc <= vec_pc;
        gie       <= 1'b0;
        if (fire_norm) begin
          link_exc <= cur_pc;
          if (gie) gie_sav_exc <= 1'b1;
        end
        if (fire_dbg) begin
          link_dbg <= cur_pc;
          if (gie) gie_sav_dbg <= 1'b1;
        end
      end else if (ie_wr) begin
        gie <= ie_wr_val;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned SLOT_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exc_req,
  input  logic [IDX_W-1:0] exc_idx,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  norm_base,
  input  logic [XLEN-1:0]  dbg_base,
  input  logic             remap_en,
  input  logic             ie_wr,
  input  logic             ie_wr_val,
  output logic             taken,
  output logic [XLEN-1:0]  target_pc,
  output logic             bad_type,
  output logic             gie,
  output logic             gie_sav_exc,
  output logic             gie_sav_dbg,
  output logic [XLEN-1:0]  link_exc,
  output logic [XLEN-1:0]  link_dbg
);
  exc_class_e      cls;
  logic [XLEN-1:0] vec_pc;
  logic            fire_norm, fire_dbg, fire_bad;

  exc_class_decode u_decode (
    .idx (exc_idx),
    .cls (cls)
  );

  exc_vector_gen #(.XLEN(XLEN), .SLOT_SHIFT(SLOT_SHIFT)) u_vector (
    .cls       (cls),
    .remap_en  (remap_en),
    .idx       (exc_idx),
    .norm_base (norm_base),
    .dbg_base  (dbg_base),
    .vec_pc    (vec_pc)
  );

  assign fire_norm = exc_req && (cls == CLS_NORMAL);
  assign fire_dbg  = exc_req && (cls == CLS_DEBUG);
  assign fire_bad  = exc_req && (cls == CLS_NONE);

  exc_state_regs #(.XLEN(XLEN)) u_state (
    .clk         (clk),
    .rst         (rst),
    .fire_norm   (fire_norm),
    .fire_dbg    (fire_dbg),
    .fire_bad    (fire_bad),
    .cur_pc      (cur_pc),
    .vec_pc      (vec_pc),
    .ie_wr       (ie_wr),
    .ie_wr_val   (ie_wr_val),
    .taken       (taken),
    .bad_type    (bad_type),
    .target_pc   (target_pc),
    .gie         (gie),
    .gie_sav_exc (gie_sav_exc),
    .gie_sav_dbg (gie_sav_dbg),
    .link_exc    (link_exc),
    .link_dbg    (link_dbg)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            exc_req,
  input logic            taken,
  input logic            bad_type,
  input logic            gie,
  input logic            gie_sav_exc,
  input logic            gie_sav_dbg,
  input logic [XLEN-1:0] link_exc,
  input logic [XLEN-1:0] target_pc
);
  AST_TAKEN_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    taken |-> $past(exc_req)); // R9
  AST_BAD_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    bad_type |-> !taken); // R1
  AST_GIE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    taken |-> !gie); // R5
  AST_SAV_EXC_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(gie_sav_exc)) |-> gie_sav_exc); // R4
  AST_SAV_DBG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(gie_sav_dbg)) |-> gie_sav_dbg); // R4
  AST_LINK_HELD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !taken) |-> $stable(link_exc)); // R2
  AST_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    taken |-> (target_pc[4:0] == 5'd0)); // R6
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_req = 1'b0;
  logic [2:0]  exc_idx = '0;
  logic [31:0] cur_pc = '0, norm_base = '0, dbg_base = '0;
  logic        remap_en = 1'b0, ie_wr = 1'b0, ie_wr_val = 1'b0;
  logic        taken, bad_type, gie, gie_sav_exc, gie_sav_dbg;
  logic [31:0] target_pc, link_exc, link_dbg;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_idx(exc_idx), .cur_pc(cur_pc),
    .norm_base(norm_base), .dbg_base(dbg_base), .remap_en(remap_en),
    .ie_wr(ie_wr), .ie_wr_val(ie_wr_val), .taken(taken), .target_pc(target_pc),
    .bad_type(bad_type), .gie(gie), .gie_sav_exc(gie_sav_exc),
    .gie_sav_dbg(gie_sav_dbg), .link_exc(link_exc), .link_dbg(link_dbg)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
  endtask

  task automatic write_ie(input logic v);
    ie_wr = 1'b1; ie_wr_val = v; tick(); ie_wr = 1'b0;
  endtask

  task automatic raise(input logic [2:0] idx, input logic [31:0] pc);
    exc_req = 1'b1; exc_idx = idx; cur_pc = pc; tick(); exc_req = 1'b0;
  endtask

  function automatic logic [31:0] exp_vec(input logic [2:0] idx, input logic rm);
    logic [31:0] b;
    b = (idx == 3'd1 || idx == 3'd3 || rm) ? dbg_base : norm_base;
    return (b & 32'hFFFF_FF00) + 32'(idx) * 32;
  endfunction

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick();
    do_reset();
    chk("R10 gie", {31'b0, gie}, 0);
    chk("R10 sav_exc", {31'b0, gie_sav_exc}, 0);
    chk("R10 sav_dbg", {31'b0, gie_sav_dbg}, 0);
    chk("R10 link_exc", link_exc, 0);
    chk("R10 link_dbg", link_dbg, 0);
    chk("R10 taken", {31'b0, taken}, 0);

    norm_base = 32'h0000_41A7;
    dbg_base  = 32'hF00F_12FF;
    for (int idx = 0; idx < 8; idx++) begin
      for (int iev = 0; iev < 2; iev++) begin
        for (int rm = 0; rm < 2; rm++) begin
          logic dbg, nrm, bd;
          logic [31:0] pc;
          dbg = (idx == 1 || idx == 3);
          bd  = (idx == 0);
          nrm = !dbg && !bd;
          pc  = 32'h1000_0000 + 32'(idx) * 16 + 32'(iev) * 4 + 32'(rm) * 8;
          do_reset();
          remap_en = rm[0];
          write_ie(iev[0]);
          chk("R11 gie write", {31'b0, gie}, 32'(iev));
          raise(3'(idx), pc);
          chk("R9 taken", {31'b0, taken}, {31'b0, !bd});
          chk("R1 bad_type", {31'b0, bad_type}, {31'b0, bd});
          chk("R5 gie", {31'b0, gie}, bd ? 32'(iev) : 32'd0);
          chk("R2 link_exc", link_exc, nrm ? pc : 32'd0);
          chk("R3 link_dbg", link_dbg, dbg ? pc : 32'd0);
          chk("R4 sav_exc", {31'b0, gie_sav_exc}, nrm ? 32'(iev) : 32'd0);
          chk("R4 sav_dbg", {31'b0, gie_sav_dbg}, dbg ? 32'(iev) : 32'd0);
          if (!bd) begin
            if (dbg) chk("R8 target", target_pc, exp_vec(3'(idx), rm[0]));
            else     chk("R7 R6 target", target_pc, exp_vec(3'(idx), rm[0]));
          end
          tick();
          chk("R9 pulse ends", {31'b0, taken}, 0);
          chk("R1 pulse ends", {31'b0, bad_type}, 0);
        end
      end
    end

    // sticky saved bits
    do_reset();
    remap_en = 1'b0;
    write_ie(1'b1);
    raise(3'd6, 32'h0000_0A00);
    raise(3'd7, 32'h0000_0B00);
    chk("R4 sav_exc sticky", {31'b0, gie_sav_exc}, 1);
    chk("R2 link updated", link_exc, 32'h0000_0B00);
    write_ie(1'b1);
    raise(3'd3, 32'h0000_0C00);
    write_ie(1'b0);
    raise(3'd1, 32'h0000_0D00);
    chk("R4 sav_dbg sticky", {31'b0, gie_sav_dbg}, 1);
    chk("R3 link updated", link_dbg, 32'h0000_0D00);

    // entry beats a simultaneous enable write
    write_ie(1'b1);
    exc_req = 1'b1; exc_idx = 3'd5; cur_pc = 32'h0000_0E00;
    ie_wr = 1'b1; ie_wr_val = 1'b1;
    tick();
    exc_req = 1'b0; ie_wr = 1'b0;
    chk("R5 priority gie", {31'b0, gie}, 0);
    chk("R2 link on collision", link_exc, 32'h0000_0E00);

    // unhandled index with loaded state
    write_ie(1'b1);
    raise(3'd0, 32'hDEAD_0000);
    chk("R1 gie kept", {31'b0, gie}, 1);
    chk("R1 link_exc kept", link_exc, 32'h0000_0E00);
    chk("R1 link_dbg kept", link_dbg, 32'h0000_0D00);
    chk("R1 no taken", {31'b0, taken}, 0);
    chk("R1 bad pulse", {31'b0, bad_type}, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule